// File: doc/BRIEF.md
# Slow-Scan Video Point Sampler

This block digitises grey levels from a raster video source using a converter far slower than the pixel rate. It converts a single point on each horizontal line. The sampling instant is set by counting pixel-rate ticks after the line strobe until the count reaches a target column. The image is covered by moving that target. In column mode the target advances by one column per frame, so a run of frames sweeps a vertical column of samples across the picture. In diagonal mode the target moves by a signed step on every line, so one frame traces one sloped scan line inside a chosen range of lines.

Software sets the mode, the start column, the slope, the line range and the frame count, then pulses `start`. Acquisition waits for the next frame strobe. Each accepted point comes out as a line index, a column index and an 8-bit grey level, qualified by a one-clock valid strobe. `done` rises once the programmed number of frames has ended. The analog front end, the converter and image storage live outside the block.

Top module: `vscan_point_sampler`

## Requirements
- R1: At most one sample is produced per video line. `out_valid` is high for exactly one clock per sample.
- R2: A line strobe clears the tick counter, and each later pixel tick advances it. The sample is taken on the tick whose count of earlier ticks in the line equals the target column. `adc_data` is captured on that tick, and `out_valid`, `out_line`, `out_col` and `out_sample` appear on the clock after it.
- R3: In column mode (`cfg_diag`=0), frame k after arming (k=0 first) uses target column `cfg_col0`+k on every line.
- R4: In diagonal mode (`cfg_diag`=1), line n uses target `cfg_col0`+n·s. Here s is +`cfg_step`, or −`cfg_step` when `cfg_slope_neg`=1. Only lines from `cfg_line_first` to `cfg_line_last` inclusive may produce samples.
- R5: A target below 0 or at 512 or above produces no sample on that line.
- R6: The line index restarts at 0 with the first line strobe after a frame strobe and counts later line strobes. Lines with index 480 or above produce no sample.
- R7: `start` arms the block only when it is neither armed nor running. No sample is produced before the first frame strobe after arming. `start` while armed or running has no effect.
- R8: `done` is low after reset. It goes high on the clock after the frame strobe that ends frame number `cfg_frames` (0 counts as 1), stays high until the next accepted `start`, and no sample is produced after it.
- R9: The configuration inputs are sampled at the frame strobe that begins each frame. Changes during a frame take no effect until the next frame.
- R10: A frame strobe overrides a line strobe in the same clock. A pixel tick that coincides with either strobe is not counted and cannot trigger a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_sync | input | 1 | One-clock frame start strobe |
| line_sync | input | 1 | One-clock line start strobe |
| pix_tick | input | 1 | One-clock pixel-rate tick |
| adc_data | input | 8 | Grey level from the external converter |
| start | input | 1 | Arm acquisition for the next frame strobe |
| cfg_diag | input | 1 | 0 column mode, 1 diagonal mode |
| cfg_col0 | input | 9 | Start column |
| cfg_slope_neg | input | 1 | Diagonal slope is negative |
| cfg_step | input | 4 | Diagonal slope magnitude, columns per line |
| cfg_line_first | input | 9 | First line accepted in diagonal mode |
| cfg_line_last | input | 9 | Last line accepted in diagonal mode |
| cfg_frames | input | 10 | Number of frames to acquire |
| done | output | 1 | Programmed frames completed |
| out_valid | output | 1 | Sample strobe |
| out_line | output | 9 | Line index of the sample |
| out_col | output | 9 | Column index of the sample |
| out_sample | output | 8 | Captured grey level |

## Verification
A sample is due on the clock after the pixel tick that triggers it. The bench drives each tick on a falling edge and reads the outputs at the next falling edge, before the following tick is driven, so every result is credited to the exact tick that caused it. `done` is due on the clock after the closing frame strobe and is read at the falling edge after that strobe. The state that arming and mode changes set up is always read back one clock later through the sample outputs of the next lines, never from inside the block.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vps_seq.sv
module vps_seq
  import vps_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LINE_W  = 9,
  parameter int FRM_W   = 10,
  parameter int SLOPE_W = 4,
  parameter int TGT_W   = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  input  logic                     start,
  input  logic                     cfg_diag,
  input  logic [COL_W-1:0]         cfg_col0,
  input  logic                     cfg_slope_neg,
  input  logic [SLOPE_W-1:0]       cfg_step,
  input  logic [LINE_W-1:0]        cfg_line_first,
  input  logic [LINE_W-1:0]        cfg_line_last,
  input  logic [FRM_W-1:0]         cfg_frames,
  output logic                     run,
  output logic                     done,
  output logic                     diag,
  output logic signed [TGT_W-1:0]  base,
  output logic signed [TGT_W-1:0]  slope,
  output logic [LINE_W-1:0]        line_first,
  output logic [LINE_W-1:0]        line_last
);

  seq_state_e               state_q, state_d;
  logic [FRM_W-1:0]         frame_q, frame_d;
  logic [FRM_W-1:0]         frames_q, frames_d;
  logic                     done_q, done_d;
  logic                     diag_q, diag_d;
  logic signed [TGT_W-1:0]  base_q, base_d;
  logic signed [TGT_W-1:0]  slope_q, slope_d;
  logic [LINE_W-1:0]        first_q, first_d;
  logic [LINE_W-1:0]        last_q, last_d;
  logic                     load;
  logic [FRM_W-1:0]         idx_next;
  logic [FRM_W:0]           frame_inc;
  logic signed [TGT_W-1:0]  step_ext;

  assign frame_inc = {1'b0, frame_q} + {{FRM_W{1'b0}}, 1'b1};
  assign step_ext  = $signed(TGT_W'(cfg_step));

  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    frames_d = frames_q;
    done_d   = done_q;
    diag_d   = diag_q;
    base_d   = base_q;
    slope_d  = slope_q;
    first_d  = first_q;
    last_d   = last_q;
    load     = 1'b0;
    idx_next = frame_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_ARMED;
          done_d   = 1'b0;
          frames_d = cfg_frames;
        end
      end
      ST_ARMED: begin
        if (frame_sync) begin
          state_d  = ST_RUN;
          load     = 1'b1;
          idx_next = '0;
        end
      end
      ST_RUN: begin
        if (frame_sync) begin
          if (frame_inc >= {1'b0, frames_q}) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            load     = 1'b1;
            idx_next = frame_inc[FRM_W-1:0];
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      frame_d = idx_next;
      diag_d  = cfg_diag;
      first_d = cfg_line_first;
      last_d  = cfg_line_last;
      if (cfg_diag) begin
        base_d  = $signed(TGT_W'(cfg_col0));
        slope_d = cfg_slope_neg ? -step_ext : step_ext;
      end else begin
        base_d  = $signed(TGT_W'(cfg_col0) + TGT_W'(idx_next));
        slope_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      frame_q  <= '0;
      frames_q <= '0;
      done_q   <= 1'b0;
      diag_q   <= 1'b0;
      base_q   <= '0;
      slope_q  <= '0;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      state_q  <= state_d;
      frame_q  <= frame_d;
      frames_q <= frames_d;
      done_q   <= done_d;
      diag_q   <= diag_d;
      base_q   <= base_d;
      slope_q  <= slope_d;
      first_q  <= first_d;
      last_q   <= last_d;
    end
  end

  assign run        = (state_q == ST_RUN);
  assign done       = done_q;
  assign diag       = diag_q;
  assign base       = base_q;
  assign slope      = slope_q;
  assign line_first = first_q;
  assign line_last  = last_q;

  AST_ARM_WAITS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !frame_sync) |=> (state_q == ST_ARMED)); // R7

  AST_RUN_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !frame_sync) |=> (state_q == ST_RUN && $stable(frame_q))); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !frame_sync) |=> ($stable(base_q) && $stable(slope_q))); // R9

  AST_DONE_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q != ST_RUN)); // R8

endmodule

// File: rtl/vps_line_timer.sv
module vps_line_timer #(
  parameter int COL_W  = 9,
  parameter int LINE_W = 9,
  parameter int TGT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  input  logic                     line_sync,
  input  logic                     pix_tick,
  input  logic signed [TGT_W-1:0]  base,
  input  logic signed [TGT_W-1:0]  slope,
  output logic                     line_open,
  output logic [LINE_W-1:0]        line_idx,
  output logic [COL_W:0]           pix_cnt,
  output logic signed [TGT_W-1:0]  target
);

  logic                     open_q, open_d;
  logic [LINE_W-1:0]        line_q, line_d;
  logic [COL_W:0]           cnt_q, cnt_d;
  logic signed [TGT_W-1:0]  tgt_q, tgt_d;

  always_comb begin
    open_d = open_q;
    line_d = line_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    if (frame_sync) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end else if (line_sync) begin
      cnt_d  = '0;
      open_d = 1'b1;
      if (!open_q) begin
        line_d = '0;
        tgt_d  = base;
      end else begin
        if (line_q != '1) line_d = line_q + 1'b1;
        tgt_d = tgt_q + slope;
      end
    end else if (pix_tick && (cnt_q != '1)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      line_q <= '0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else begin
      open_q <= open_d;
      line_q <= line_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
    end
  end

  assign line_open = open_q;
  assign line_idx  = line_q;
  assign pix_cnt   = cnt_q;
  assign target    = tgt_q;

  AST_LINE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    line_sync |=> (cnt_q == '0)); // R2

  AST_FRAME_CLOSES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> !open_q); // R6

endmodule

// File: rtl/vps_capture.sv
module vps_capture #(
  parameter int COL_W     = 9,
  parameter int LINE_W    = 9,
  parameter int SMP_W     = 8,
  parameter int TGT_W     = 24,
  parameter int NUM_LINES = 480,
  parameter int NUM_COLS  = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     diag,
  input  logic [LINE_W-1:0]        line_first,
  input  logic [LINE_W-1:0]        line_last,
  input  logic                     frame_sync,
  input  logic                     line_sync,
  input  logic                     pix_tick,
  input  logic                     line_open,
  input  logic [LINE_W-1:0]        line_idx,
  input  logic [COL_W:0]           pix_cnt,
  input  logic signed [TGT_W-1:0]  target,
  input  logic [SMP_W-1:0]         adc_data,
  output logic                     out_valid,
  output logic [LINE_W-1:0]        out_line,
  output logic [COL_W-1:0]         out_col,
  output logic [SMP_W-1:0]         out_sample
);

  localparam logic signed [TGT_W-1:0] COLS_T  = TGT_W'(NUM_COLS);
  localparam logic [LINE_W:0]         LINES_T = (LINE_W+1)'(NUM_LINES);

  logic              line_ok, range_ok, col_ok, hit;
  logic              taken_q, taken_d;
  logic              vld_q;
  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  col_q;
  logic [SMP_W-1:0]  smp_q;

  assign line_ok  = ({1'b0, line_idx} < LINES_T);
  assign range_ok = !diag || ((line_idx >= line_first) && (line_idx <= line_last));
  assign col_ok   = !target[TGT_W-1] && (target < COLS_T)
                    && (pix_cnt == target[COL_W:0]);
  assign hit      = run && line_open && pix_tick && !line_sync && !frame_sync
                    && line_ok && range_ok && col_ok;

  always_comb begin
    taken_d = taken_q;
    if (line_sync || frame_sync) taken_d = 1'b0;
    else if (hit)                taken_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      taken_q <= taken_d;
      vld_q   <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      col_q  <= '0;
      smp_q  <= '0;
    end else if (hit) begin
      line_q <= line_idx;
      col_q  <= pix_cnt[COL_W-1:0];
      smp_q  <= adc_data;
    end
  end

  assign out_valid  = vld_q;
  assign out_line   = line_q;
  assign out_col    = col_q;
  assign out_sample = smp_q;

  AST_ONE_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !taken_q); // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R1

  AST_LINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ({1'b0, line_q} < LINES_T)); // R6

  AST_SYNC_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync || frame_sync) |=> !vld_q); // R10

endmodule

// File: rtl/vscan_point_sampler.sv
module vscan_point_sampler #(
  parameter int LINE_W    = 9,
  parameter int COL_W     = 9,
  parameter int SMP_W     = 8,
  parameter int FRM_W     = 10,
  parameter int SLOPE_W   = 4,
  parameter int NUM_LINES = 480,
  parameter int NUM_COLS  = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic               line_sync,
  input  logic               pix_tick,
  input  logic [SMP_W-1:0]   adc_data,
  input  logic               start,
  input  logic               cfg_diag,
  input  logic [COL_W-1:0]   cfg_col0,
  input  logic               cfg_slope_neg,
  input  logic [SLOPE_W-1:0] cfg_step,
  input  logic [LINE_W-1:0]  cfg_line_first,
  input  logic [LINE_W-1:0]  cfg_line_last,
  input  logic [FRM_W-1:0]   cfg_frames,
  output logic               done,
  output logic               out_valid,
  output logic [LINE_W-1:0]  out_line,
  output logic [COL_W-1:0]   out_col,
  output logic [SMP_W-1:0]   out_sample
);

  localparam int TGT_W = LINE_W + SLOPE_W + COL_W + 2;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic                     run, diag;
  logic signed [TGT_W-1:0]  base, slope, target;
  logic [LINE_W-1:0]        line_first, line_last, line_idx;
  logic                     line_open;
  logic [COL_W:0]           pix_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vps_seq #(
    .COL_W(COL_W), .LINE_W(LINE_W), .FRM_W(FRM_W),
    .SLOPE_W(SLOPE_W), .TGT_W(TGT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .frame_sync(frame_sync), .start(start),
    .cfg_diag(cfg_diag), .cfg_col0(cfg_col0), .cfg_slope_neg(cfg_slope_neg),
    .cfg_step(cfg_step), .cfg_line_first(cfg_line_first),
    .cfg_line_last(cfg_line_last), .cfg_frames(cfg_frames),
    .run(run), .done(done), .diag(diag), .base(base), .slope(slope),
    .line_first(line_first), .line_last(line_last)
  );

  vps_line_timer #(
    .COL_W(COL_W), .LINE_W(LINE_W), .TGT_W(TGT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_int_n), .frame_sync(frame_sync),
    .line_sync(line_sync), .pix_tick(pix_tick), .base(base), .slope(slope),
    .line_open(line_open), .line_idx(line_idx), .pix_cnt(pix_cnt),
    .target(target)
  );

  vps_capture #(
    .COL_W(COL_W), .LINE_W(LINE_W), .SMP_W(SMP_W), .TGT_W(TGT_W),
    .NUM_LINES(NUM_LINES), .NUM_COLS(NUM_COLS)
  ) u_cap (
    .clk(clk), .rst_n(rst_int_n), .run(run), .diag(diag),
    .line_first(line_first), .line_last(line_last),
    .frame_sync(frame_sync), .line_sync(line_sync), .pix_tick(pix_tick),
    .line_open(line_open), .line_idx(line_idx), .pix_cnt(pix_cnt),
    .target(target), .adc_data(adc_data), .out_valid(out_valid),
    .out_line(out_line), .out_col(out_col), .out_sample(out_sample)
  );

endmodule

// File: tb/sim_vscan_point_sampler.sv
module sim_vscan_point_sampler;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_sync, line_sync, pix_tick, start;
  logic [7:0] adc_data;
  logic       cfg_diag, cfg_slope_neg;
  logic [8:0] cfg_col0, cfg_line_first, cfg_line_last;
  logic [3:0] cfg_step;
  logic [9:0] cfg_frames;
  logic       done, out_valid;
  logic [8:0] out_line, out_col;
  logic [7:0] out_sample;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vscan_point_sampler u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .line_sync(line_sync),
    .pix_tick(pix_tick), .adc_data(adc_data), .start(start),
    .cfg_diag(cfg_diag), .cfg_col0(cfg_col0), .cfg_slope_neg(cfg_slope_neg),
    .cfg_step(cfg_step), .cfg_line_first(cfg_line_first),
    .cfg_line_last(cfg_line_last), .cfg_frames(cfg_frames), .done(done),
    .out_valid(out_valid), .out_line(out_line), .out_col(out_col),
    .out_sample(out_sample)
  );

  function automatic logic [7:0] pat(input int ln, input int t);
    return 8'((ln * 37 + t * 5 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // One video line: strobe, then nticks consecutive ticks. exp_col < 0 means no sample.
  task automatic do_line(input int ln, input int exp_col, input int nticks,
                         input bit tick_on_sync, input string req);
    int n_vld = 0;
    int got_t = -1;
    int got_line = -1;
    int got_col = -1;
    int got_smp = -1;
    bit ok;
    @(negedge clk);
    line_sync = 1'b1; pix_tick = tick_on_sync; adc_data = 8'hEE;
    for (int t = 0; t < nticks; t++) begin
      @(negedge clk);
      if (t > 0 && out_valid) begin
        n_vld++; got_t = t - 1;
        got_line = int'(out_line); got_col = int'(out_col); got_smp = int'(out_sample);
      end
      line_sync = 1'b0; pix_tick = 1'b1; adc_data = pat(ln, t);
    end
    @(negedge clk);
    if (out_valid) begin
      n_vld++; got_t = nticks - 1;
      got_line = int'(out_line); got_col = int'(out_col); got_smp = int'(out_sample);
    end
    pix_tick = 1'b0; line_sync = 1'b0;
    if (exp_col < 0) ok = (n_vld == 0);
    else ok = (n_vld == 1) && (got_t == exp_col) && (got_col == exp_col)
              && (got_line == ln) && (got_smp == int'(pat(ln, exp_col)));
    chk(ok, req, $sformatf("line %0d: samples=%0d tick=%0d col=%0d line=%0d smp=%0h expected col=%0d smp=%0h",
        ln, n_vld, got_t, got_col, got_line, got_smp, exp_col,
        (exp_col < 0) ? 0 : int'(pat(ln, exp_col))));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; frame_sync = 1'b0; line_sync = 1'b0; pix_tick = 1'b0;
    start = 1'b0; adc_data = '0; cfg_diag = 1'b0; cfg_col0 = '0;
    cfg_slope_neg = 1'b0; cfg_step = '0; cfg_line_first = '0;
    cfg_line_last = '0; cfg_frames = 10'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", $sformatf("reset out_valid=%0b expected 0", out_valid));
    chk(done == 1'b0, "R8", $sformatf("reset done=%0b expected 0", done));
  endtask

  task automatic test_unarmed();
    pulse_frame();
    do_line(0, -1, 4, 1'b0, "R7");
    do_line(1, -1, 4, 1'b0, "R7");
  endtask

  task automatic test_column();
    cfg_diag = 1'b0; cfg_col0 = 9'd1; cfg_frames = 10'd3;
    pulse_start();
    for (int f = 0; f < 3; f++) begin
      pulse_frame();
      chk(done == 1'b0, "R8", $sformatf("frame %0d done=%0b expected 0", f, done));
      if (f == 0) cfg_col0 = 9'd6;      // mid-frame change, R9
      if (f == 1) pulse_start();         // ignored while running, R7
      for (int ln = 0; ln < 3; ln++) do_line(ln, 1 + f, 6, 1'b0, "R3");
      cfg_col0 = 9'd1;
    end
    pulse_frame();
    chk(done == 1'b1, "R8", $sformatf("after 3 frames done=%0b expected 1", done));
    pulse_frame();
    do_line(0, -1, 6, 1'b0, "R8");
  endtask

  task automatic test_diag_pos();
    cfg_diag = 1'b1; cfg_col0 = 9'd2; cfg_step = 4'd1; cfg_slope_neg = 1'b0;
    cfg_line_first = 9'd1; cfg_line_last = 9'd2; cfg_frames = 10'd1;
    pulse_start();
    chk(done == 1'b0, "R7", $sformatf("after start done=%0b expected 0", done));
    pulse_frame();
    do_line(0, -1, 8, 1'b0, "R4");
    do_line(1, 3, 8, 1'b0, "R4");
    do_line(2, 4, 8, 1'b0, "R4");
    do_line(3, -1, 8, 1'b0, "R4");
    pulse_frame();
    chk(done == 1'b1, "R8", $sformatf("diag frame done=%0b expected 1", done));
  endtask

  task automatic test_diag_neg();
    cfg_diag = 1'b1; cfg_col0 = 9'd5; cfg_step = 4'd2; cfg_slope_neg = 1'b1;
    cfg_line_first = 9'd0; cfg_line_last = 9'd3; cfg_frames = 10'd1;
    pulse_start();
    pulse_frame();
    do_line(0, 5, 8, 1'b0, "R4");
    do_line(1, 3, 8, 1'b0, "R4");
    do_line(2, 1, 8, 1'b0, "R4");
    do_line(3, -1, 8, 1'b0, "R5");
    pulse_frame();
  endtask

  task automatic test_edge_cols();
    cfg_diag = 1'b0; cfg_col0 = 9'd511; cfg_frames = 10'd2;
    pulse_start();
    pulse_frame();
    do_line(0, 511, 512, 1'b0, "R5");
    do_line(1, 511, 512, 1'b0, "R2");
    pulse_frame();
    do_line(0, -1, 512, 1'b0, "R5");
    pulse_frame();
    chk(done == 1'b1, "R8", $sformatf("edge test done=%0b expected 1", done));
  endtask

  task automatic test_line_limit();
    cfg_diag = 1'b0; cfg_col0 = 9'd0; cfg_frames = 10'd1;
    pulse_start();
    pulse_frame();
    for (int ln = 0; ln < 482; ln++) do_line(ln, (ln < 480) ? 0 : -1, 1, 1'b0, "R6");
    pulse_frame();
  endtask

  task automatic test_sync_priority();
    cfg_diag = 1'b0; cfg_col0 = 9'd1; cfg_frames = 10'd1;
    pulse_start();
    pulse_frame();
    do_line(0, 1, 3, 1'b1, "R10");
    do_line(1, 1, 3, 1'b1, "R10");
    pulse_frame();
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after 150000 cycles");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_unarmed();
    test_column();
    test_diag_pos();
    test_diag_neg();
    test_edge_cols();
    test_line_limit();
    test_sync_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule